// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits in a processor front end, between the interrupt controller, the instruction pipeline and the data memory. Each cycle it looks at four request sources: an exception, a fast interrupt, a prioritised hardware interrupt and a software trap (a numbered trap or a break). It applies each source's masking rule against the current status word, picks one winner by fixed priority, and then runs the entry sequence for it. The sequence saves the program counter and status word, builds the new status word and loads the new program counter.

A fast interrupt takes a short path. The old PC and status word go into backup registers, the new PC comes from a dedicated fast-vector input, and the priority level is forced to its maximum. Every other class pushes PC and then the status word on a stack write port. It then reads its handler address from memory through a request/valid read port: from the vector table for hardware and software traps, or from a fixed exception area near the top of the address space. Hardware and fast entries pulse an acknowledge back to the interrupt controller. A sleep flag is kept as well; any pending request clears it, whether or not that request is masked.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request is taken only when the enable flag (status bit 16) is 1 and the current level (status bits 27:24) is strictly below `hw_lvl`.
- R2: A fast request is taken only when the enable flag is 1 and the current level is not 15.
- R3: A software trap is taken whatever the enable flag. A numbered trap uses `sw_vec`; a break (`sw_brk`) uses vector 0.
- R4: When several requests are taken in the same cycle, priority is exception, then fast, then hardware, then software.
- R5: When an entry completes, `new_psw` equals the saved status word with the enable flag, the stack-select flag (bit 17) and the mode flag (bit 20) cleared.
- R6: A fast entry completes one cycle after acceptance. It gives one `bk_we` pulse carrying the old PC and status word, `new_pc` = `fast_pc`, level 15, and one `ack` pulse. It makes no push and no read.
- R7: A hardware entry sets the level to `hw_lvl`, pulses `ack` once, and reads its handler from `tbl_base + vector*4`. Software traps read from the same table.
- R8: An exception reads its handler from `0xFFFFFFC0 + exc_vec*4`. Software and exception entries keep the current level and do not pulse `ack`.
- R9: A non-fast entry pushes the old PC and then the old status word in two consecutive cycles, before any read request.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_valid`. `done` follows one cycle later, with `new_pc` equal to the returned data.
- R11: `sleep_req` sets `asleep`. Any pending request, masked or not, clears it, and clearing wins over setting.
- R12: After reset, `busy`, `done`, `ack`, `bk_we`, `push_en`, `rd_req` and `asleep` are all 0.
- R13: Requests that arrive while an entry is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 1 | Hardware interrupt pending |
| hw_lvl | input | 4 | Priority level of the hardware request |
| hw_vec | input | 8 | Table vector of the hardware request |
| fast_req | input | 1 | Fast interrupt pending |
| sw_req | input | 1 | Numbered software trap |
| sw_brk | input | 1 | Break trap (vector 0) |
| sw_vec | input | 8 | Vector of the numbered trap |
| exc_req | input | 1 | Exception pending |
| exc_vec | input | 4 | Exception number |
| pc_in | input | 32 | Current program counter |
| psw_in | input | 32 | Current status word |
| tbl_base | input | 32 | Vector table base address |
| fast_pc | input | 32 | Fast interrupt handler address |
| sleep_req | input | 1 | Enter sleep |
| busy | output | 1 | Entry sequence in progress |
| asleep | output | 1 | Sleep flag |
| push_en | output | 1 | Stack push strobe |
| push_data | output | 32 | Word to push |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | Entry complete; new_pc and new_psw valid |
| new_pc | output | 32 | Handler address |
| new_psw | output | 32 | Status word for the handler |
| ack | output | 1 | Acknowledge pulse to the interrupt controller |
| bk_we | output | 1 | Backup register write strobe (fast entry) |
| bk_pc | output | 32 | PC to back up |
| bk_psw | output | 32 | Status word to back up |

## Verification
The fetch assertions assume that the memory side raises `rd_valid` only while `rd_req` is high, and for a single cycle per request. The bench's memory responder waits a programmable number of cycles after it sees `rd_req` and then returns one valid beat. The responder drops `rd_valid` as soon as the request goes away. Requests are presented only when the sequencer is idle, except in the test for R13. That test pulses a fast request in the middle of a fetch and checks that no second entry follows.

// File: rtl/irq_entry_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package irq_entry_pkg;
    typedef enum logic [1:0] {
        CLS_EXC,
        CLS_FAST,
        CLS_HW,
        CLS_SW
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_FETCH,
        ST_DONE
    } st_e;
endpackage

// File: rtl/irq_entry_arb.sv
// Acceptance and arbitration. Applies each class's masking rule and picks
// one winner (exception > fast > hardware > software). It also works out
// the winner's target: the handler PC for fast entries, the vector read
// address for all others, and the priority level the handler will run at.
// Assumes: purely combinational; the caller gates the grant with its idle state.
module irq_entry_arb
    import irq_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter int VW = 8,
    parameter int LW = 4,
    parameter int EW = 4,
    parameter logic [AW-1:0] EXC_BASE = 32'hFFFF_FFC0
) (
    input  logic          hw_req,
    input  logic [LW-1:0] hw_lvl,
    input  logic [VW-1:0] hw_vec,
    input  logic          fast_req,
    input  logic          sw_req,
    input  logic          sw_brk,
    input  logic [VW-1:0] sw_vec,
    input  logic          exc_req,
    input  logic [EW-1:0] exc_vec,
    input  logic          ie,
    input  logic [LW-1:0] ipl,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] fast_pc,
    output logic          grant,
    output cls_e          cls,
    output logic [AW-1:0] tgt,
    output logic [LW-1:0] tgt_ipl
);
    localparam logic [LW-1:0] LMAX = '1;
    localparam int TPAD = AW - VW - 2;
    localparam int EPAD = AW - EW - 2;

    logic          ok_exc, ok_fast, ok_hw, ok_sw;
    logic [VW-1:0] soft_vec;

    // Masking rule of each class
    always_comb begin
        ok_exc   = exc_req;
        ok_fast  = fast_req & ie & (ipl != LMAX);
        ok_hw    = hw_req & ie & (ipl < hw_lvl);
        ok_sw    = sw_req | sw_brk;
        soft_vec = sw_brk ? '0 : sw_vec;
    end

    // Fixed-priority pick and target computation
    always_comb begin
        grant   = ok_exc | ok_fast | ok_hw | ok_sw;
        cls     = CLS_SW;
        tgt     = tbl_base + {{TPAD{1'b0}}, soft_vec, 2'b00};
        tgt_ipl = ipl;
        if (ok_exc) begin
            cls = CLS_EXC;
            tgt = EXC_BASE + {{EPAD{1'b0}}, exc_vec, 2'b00};
        end else if (ok_fast) begin
            cls     = CLS_FAST;
            tgt     = fast_pc;
            tgt_ipl = LMAX;
        end else if (ok_hw) begin
            cls     = CLS_HW;
            tgt     = tbl_base + {{TPAD{1'b0}}, hw_vec, 2'b00};
            tgt_ipl = hw_lvl;
        end
    end
endmodule

// File: rtl/irq_entry_fsm.sv
// Entry sequencer. It captures the winning request while idle, then walks
// push-PC, push-PSW and fetch for table and exception entries, or jumps
// straight to done for fast entries.
// Assumes: rd_valid is high only while rd_req is high, and for one cycle.
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  cls_e          cls,
    input  logic [AW-1:0] tgt,
    input  logic [LW-1:0] tgt_ipl,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] psw_in,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          push_en,
    output logic [DW-1:0] push_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic          ack,
    output logic          bk_we,
    output logic [AW-1:0] bk_pc,
    output logic [DW-1:0] bk_psw,
    output logic [DW-1:0] sav_psw,
    output logic [LW-1:0] sav_ipl
);
    st_e           st, st_nx;
    cls_e          cls_q;
    logic [AW-1:0] tgt_q, pc_q, npc_q;
    logic [DW-1:0] psw_q;
    logic [LW-1:0] ipl_q;

    // Next-state decode
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:     if (grant) st_nx = (cls == CLS_FAST) ? ST_DONE : ST_PUSH_PC;
            ST_PUSH_PC:  st_nx = ST_PUSH_PSW;
            ST_PUSH_PSW: st_nx = ST_FETCH;
            ST_FETCH:    if (rd_valid) st_nx = ST_DONE;
            ST_DONE:     st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Capture of request context at acceptance and of fetched handler PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= CLS_SW;
            tgt_q <= '0;
            pc_q  <= '0;
            psw_q <= '0;
            ipl_q <= '0;
            npc_q <= '0;
        end else if (st == ST_IDLE && grant) begin
            cls_q <= cls;
            tgt_q <= tgt;
            pc_q  <= pc_in;
            psw_q <= psw_in;
            ipl_q <= tgt_ipl;
            npc_q <= tgt;
        end else if (st == ST_FETCH && rd_valid) begin
            npc_q <= rd_data;
        end
    end

    // Output decode from state and captured context
    always_comb begin
        busy      = (st != ST_IDLE);
        push_en   = (st == ST_PUSH_PC) || (st == ST_PUSH_PSW);
        push_data = (st == ST_PUSH_PSW) ? psw_q : pc_q;
        rd_req    = (st == ST_FETCH);
        rd_addr   = tgt_q;
        done      = (st == ST_DONE);
        new_pc    = npc_q;
        ack       = done && (cls_q == CLS_FAST || cls_q == CLS_HW);
        bk_we     = done && (cls_q == CLS_FAST);
        bk_pc     = pc_q;
        bk_psw    = psw_q;
        sav_psw   = psw_q;
        sav_ipl   = ipl_q;
    end

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
    // R10
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_valid |=> done && new_pc == $past(rd_data));
    // R9
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en && !rd_req && $past(push_en) |=> rd_req);
endmodule

// File: rtl/irq_entry_psw.sv
// Status word builder. It clears the enable, stack-select and mode flags
// of the saved word and inserts the handler's priority level.
// Assumes: the bit positions are parameters and do not overlap.
module irq_entry_psw #(
    parameter int DW        = 32,
    parameter int LW        = 4,
    parameter int IE_BIT    = 16,
    parameter int STK_BIT   = 17,
    parameter int MODE_BIT  = 20,
    parameter int IPL_LSB   = 24
) (
    input  logic [DW-1:0] sav_psw,
    input  logic [LW-1:0] sav_ipl,
    output logic [DW-1:0] new_psw
);
    // Flag clearing and level insertion
    always_comb begin
        new_psw                   = sav_psw;
        new_psw[IE_BIT]           = 1'b0;
        new_psw[STK_BIT]          = 1'b0;
        new_psw[MODE_BIT]         = 1'b0;
        new_psw[IPL_LSB +: LW]    = sav_ipl;
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Top of the interrupt entry sequencer. It wires arbitration, the entry
// state machine and the status builder together, and holds the sleep flag.
// Assumes: psw_in and pc_in are stable while the block is idle and a request
// is presented.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int VW       = 8,
    parameter int LW       = 4,
    parameter int EW       = 4,
    parameter int IE_BIT   = 16,
    parameter int STK_BIT  = 17,
    parameter int MODE_BIT = 20,
    parameter int IPL_LSB  = 24,
    parameter logic [AW-1:0] EXC_BASE = 32'hFFFF_FFC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_req,
    input  logic [LW-1:0] hw_lvl,
    input  logic [VW-1:0] hw_vec,
    input  logic          fast_req,
    input  logic          sw_req,
    input  logic          sw_brk,
    input  logic [VW-1:0] sw_vec,
    input  logic          exc_req,
    input  logic [EW-1:0] exc_vec,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] psw_in,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] fast_pc,
    input  logic          sleep_req,
    output logic          busy,
    output logic          asleep,
    output logic          push_en,
    output logic [DW-1:0] push_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] new_psw,
    output logic          ack,
    output logic          bk_we,
    output logic [AW-1:0] bk_pc,
    output logic [DW-1:0] bk_psw
);
    localparam logic [LW-1:0] LMAX = '1;

    logic          grant, idle_grant, any_pend;
    cls_e          cls;
    logic [AW-1:0] tgt;
    logic [LW-1:0] tgt_ipl, sav_ipl;
    logic [DW-1:0] sav_psw;

    irq_entry_arb #(.AW(AW), .VW(VW), .LW(LW), .EW(EW), .EXC_BASE(EXC_BASE)) u_arb (
        .hw_req(hw_req), .hw_lvl(hw_lvl), .hw_vec(hw_vec),
        .fast_req(fast_req), .sw_req(sw_req), .sw_brk(sw_brk), .sw_vec(sw_vec),
        .exc_req(exc_req), .exc_vec(exc_vec),
        .ie(psw_in[IE_BIT]), .ipl(psw_in[IPL_LSB +: LW]),
        .tbl_base(tbl_base), .fast_pc(fast_pc),
        .grant(grant), .cls(cls), .tgt(tgt), .tgt_ipl(tgt_ipl)
    );

    // The state machine only accepts while idle, so the raw grant passes through
    assign idle_grant = grant;

    irq_entry_fsm #(.AW(AW), .DW(DW), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .grant(idle_grant), .cls(cls), .tgt(tgt), .tgt_ipl(tgt_ipl),
        .pc_in(pc_in), .psw_in(psw_in),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .push_en(push_en), .push_data(push_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .done(done), .new_pc(new_pc), .ack(ack),
        .bk_we(bk_we), .bk_pc(bk_pc), .bk_psw(bk_psw),
        .sav_psw(sav_psw), .sav_ipl(sav_ipl)
    );

    irq_entry_psw #(.DW(DW), .LW(LW), .IE_BIT(IE_BIT), .STK_BIT(STK_BIT),
                    .MODE_BIT(MODE_BIT), .IPL_LSB(IPL_LSB)) u_psw (
        .sav_psw(sav_psw), .sav_ipl(sav_ipl), .new_psw(new_psw)
    );

    // Any request, masked or not, counts as pending for wake-up
    assign any_pend = hw_req | fast_req | sw_req | sw_brk | exc_req;

    // Sleep flag: wake-up wins over a new sleep request
    always_ff @(posedge clk) begin
        if (!rst_n)         asleep <= 1'b0;
        else if (any_pend)  asleep <= 1'b0;
        else if (sleep_req) asleep <= 1'b1;
    end

    // R5
    entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !new_psw[IE_BIT] && !new_psw[STK_BIT] && !new_psw[MODE_BIT]);
    // R6
    fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_we |-> new_psw[IPL_LSB +: LW] == LMAX && ack && !push_en);
    // R11
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> !asleep);
    // R13
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_req = 1'b0, fast_req = 1'b0, sw_req = 1'b0, sw_brk = 1'b0, exc_req = 1'b0;
    logic [3:0]  hw_lvl = '0, exc_vec = '0;
    logic [7:0]  hw_vec = '0, sw_vec = '0;
    logic [31:0] pc_in = 32'h0000_0400, psw_in = '0;
    logic [31:0] tbl_base = 32'h0000_1000, fast_pc = 32'h0000_8000;
    logic        sleep_req = 1'b0, rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, asleep, push_en, rd_req, done, ack, bk_we;
    logic [31:0] push_data, rd_addr, new_pc, new_psw, bk_pc, bk_psw;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .hw_req(hw_req), .hw_lvl(hw_lvl), .hw_vec(hw_vec),
        .fast_req(fast_req), .sw_req(sw_req), .sw_brk(sw_brk), .sw_vec(sw_vec),
        .exc_req(exc_req), .exc_vec(exc_vec),
        .pc_in(pc_in), .psw_in(psw_in), .tbl_base(tbl_base), .fast_pc(fast_pc),
        .sleep_req(sleep_req), .busy(busy), .asleep(asleep),
        .push_en(push_en), .push_data(push_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .new_pc(new_pc), .new_psw(new_psw), .ack(ack),
        .bk_we(bk_we), .bk_pc(bk_pc), .bk_psw(bk_psw)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;

    // Watchdog
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Observation state collected by tick
    int          n_ack, n_push, n_bk, n_done, push_at_rd, mem_delay, wcnt;
    bit          rd_seen;
    logic [31:0] push0, push1, seen_addr, got_pc, got_psw, got_bkpc, got_bkpsw;

    task automatic clr_obs();
        n_ack = 0; n_push = 0; n_bk = 0; n_done = 0; push_at_rd = -1;
        rd_seen = 1'b0; push0 = '0; push1 = '0; seen_addr = '0;
        got_pc = '0; got_psw = '0; got_bkpc = '0; got_bkpsw = '0; wcnt = 0;
    endtask

    // One cycle: sample outputs at the falling edge and run the memory model
    task automatic tick();
        @(negedge clk);
        if (ack) n_ack++;
        if (push_en) begin
            if (n_push == 0) push0 = push_data; else push1 = push_data;
            n_push++;
        end
        if (bk_we) begin n_bk++; got_bkpc = bk_pc; got_bkpsw = bk_psw; end
        if (done) begin n_done++; got_pc = new_pc; got_psw = new_psw; end
        if (rd_req) begin
            if (!rd_seen) begin push_at_rd = n_push; seen_addr = rd_addr; end
            rd_seen = 1'b1;
            if (rd_addr != seen_addr) seen_addr = 32'hDEAD_BEEF;
            if (wcnt >= mem_delay && !rd_valid) begin
                rd_valid = 1'b1; rd_data = ~rd_addr;
            end else begin
                rd_valid = 1'b0; wcnt++;
            end
        end else begin
            rd_valid = 1'b0; wcnt = 0;
        end
    endtask

    function automatic logic [31:0] mk_psw(input logic ie, input logic [3:0] ipl);
        return {4'h0, ipl, 3'b000, 1'b1, 2'b00, 1'b1, ie, 16'h00A5};
    endfunction

    function automatic logic [31:0] exp_psw(input logic [31:0] p, input logic [3:0] ipl);
        logic [31:0] r;
        r = p;
        r[16] = 1'b0; r[17] = 1'b0; r[20] = 1'b0;
        r[27:24] = ipl;
        return r;
    endfunction

    typedef struct packed {
        logic        hw;
        logic [3:0]  lvl;
        logic [7:0]  hvec;
        logic        fast;
        logic        sw;
        logic        brk;
        logic [7:0]  svec;
        logic        exc;
        logic [3:0]  evec;
        logic        ie;
        logic [3:0]  ipl;
        logic        take;
        logic [1:0]  kind;   // 1 fast, 2 memory fetch
        logic [31:0] addr;
        logic [3:0]  eipl;
        logic        eack;
    } row_t;

    localparam int NROW = 14;
    localparam row_t TBL [NROW] = '{
        // R1 taken: level 3 below 5
        '{1'b1,4'd5,8'h40,1'b0,1'b0,1'b0,8'h00,1'b0,4'd0,1'b1,4'd3,1'b1,2'd2,32'h0000_1100,4'd5,1'b1},
        // R1 equal level refused
        '{1'b1,4'd3,8'h40,1'b0,1'b0,1'b0,8'h00,1'b0,4'd0,1'b1,4'd3,1'b0,2'd0,32'h0,4'd3,1'b0},
        // R1 enable clear refused
        '{1'b1,4'd7,8'h40,1'b0,1'b0,1'b0,8'h00,1'b0,4'd0,1'b0,4'd0,1'b0,2'd0,32'h0,4'd0,1'b0},
        // R2 level 14 taken
        '{1'b0,4'd0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,4'd0,1'b1,4'd14,1'b1,2'd1,32'h0000_8000,4'd15,1'b1},
        // R2 level 15 refused
        '{1'b0,4'd0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,4'd0,1'b1,4'd15,1'b0,2'd0,32'h0,4'd15,1'b0},
        // R2 enable clear refused
        '{1'b0,4'd0,8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,4'd0,1'b0,4'd0,1'b0,2'd0,32'h0,4'd0,1'b0},
        // R3 trap with enable clear
        '{1'b0,4'd0,8'h00,1'b0,1'b1,1'b0,8'h21,1'b0,4'd0,1'b0,4'd9,1'b1,2'd2,32'h0000_1084,4'd9,1'b0},
        // R3 break uses vector 0
        '{1'b0,4'd0,8'h00,1'b0,1'b0,1'b1,8'h33,1'b0,4'd0,1'b1,4'd2,1'b1,2'd2,32'h0000_1000,4'd2,1'b0},
        // R4 hardware over trap
        '{1'b1,4'd6,8'h10,1'b0,1'b1,1'b0,8'h21,1'b0,4'd0,1'b1,4'd0,1'b1,2'd2,32'h0000_1040,4'd6,1'b1},
        // R4 masked hardware lets trap through
        '{1'b1,4'd6,8'h10,1'b0,1'b1,1'b0,8'h05,1'b0,4'd0,1'b0,4'd0,1'b1,2'd2,32'h0000_1014,4'd0,1'b0},
        // R4 exception over hardware, R8 address
        '{1'b1,4'd6,8'h10,1'b0,1'b0,1'b0,8'h00,1'b1,4'd3,1'b1,4'd0,1'b1,2'd2,32'hFFFF_FFCC,4'd0,1'b0},
        // R4 fast over hardware
        '{1'b1,4'd6,8'h10,1'b1,1'b0,1'b0,8'h00,1'b0,4'd0,1'b1,4'd0,1'b1,2'd1,32'h0000_8000,4'd15,1'b1},
        // R8 last exception slot
        '{1'b0,4'd0,8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,4'd15,1'b1,4'd4,1'b1,2'd2,32'hFFFF_FFFC,4'd4,1'b0},
        // R7 top level and top vector
        '{1'b1,4'd15,8'hFF,1'b0,1'b0,1'b0,8'h00,1'b0,4'd0,1'b1,4'd14,1'b1,2'd2,32'h0000_13FC,4'd15,1'b1}
    };

    initial begin
        logic [31:0] p;
        mem_delay = 2;
        clr_obs();
        repeat (3) tick();
        // R12 reset state
        chk({busy, done, ack, bk_we, push_en, rd_req, asleep} == 7'b0, "R12 reset outputs",
            {25'b0, busy, done, ack, bk_we, push_en, rd_req, asleep}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk({busy, done, ack, bk_we, push_en, rd_req, asleep} == 7'b0, "R12 after release",
            {25'b0, busy, done, ack, bk_we, push_en, rd_req, asleep}, 32'h0);

        for (int i = 0; i < NROW; i++) begin
            row_t r;
            r = TBL[i];
            p = mk_psw(r.ie, r.ipl);
            clr_obs();
            psw_in = p;
            hw_req = r.hw; hw_lvl = r.lvl; hw_vec = r.hvec; fast_req = r.fast;
            sw_req = r.sw; sw_brk = r.brk; sw_vec = r.svec; exc_req = r.exc; exc_vec = r.evec;
            tick();
            hw_req = 1'b0; fast_req = 1'b0; sw_req = 1'b0; sw_brk = 1'b0; exc_req = 1'b0;
            for (int k = 0; k < 20 && n_done == 0; k++) tick();
            repeat (4) tick();
            chk(n_done == (r.take ? 1 : 0), $sformatf("R1 R2 R3 acceptance row %0d", i),
                n_done, {31'b0, r.take});
            chk(n_ack == (r.eack ? 1 : 0), $sformatf("R6 R7 R8 ack row %0d", i), n_ack, {31'b0, r.eack});
            if (r.kind == 2'd1) begin
                chk(got_pc == fast_pc, $sformatf("R6 fast pc row %0d", i), got_pc, fast_pc);
                chk(n_bk == 1 && got_bkpc == pc_in && got_bkpsw == p,
                    $sformatf("R6 backup row %0d", i), got_bkpsw, p);
                chk(n_push == 0 && !rd_seen, $sformatf("R6 no push/read row %0d", i), n_push, 0);
            end else if (r.kind == 2'd2) begin
                chk(seen_addr == r.addr, $sformatf("R7 R8 vector address row %0d", i), seen_addr, r.addr);
                chk(got_pc == ~r.addr, $sformatf("R10 new pc row %0d", i), got_pc, ~r.addr);
                chk(n_push == 2 && push0 == pc_in && push1 == p && push_at_rd == 2,
                    $sformatf("R9 pushes row %0d", i), push1, p);
                chk(n_bk == 0, $sformatf("R9 no backup row %0d", i), n_bk, 0);
            end else begin
                chk(n_push == 0 && !rd_seen && n_bk == 0, $sformatf("R1 R2 idle row %0d", i), n_push, 0);
            end
            if (r.take)
                chk(got_psw == exp_psw(p, r.eipl), $sformatf("R5 new psw row %0d", i),
                    got_psw, exp_psw(p, r.eipl));
        end

        // R10 long memory latency, R13 fast request during fetch ignored
        clr_obs();
        mem_delay = 7;
        p = mk_psw(1'b1, 4'd0);
        psw_in = p; sw_req = 1'b1; sw_vec = 8'h02;
        tick();
        sw_req = 1'b0;
        for (int k = 0; k < 4; k++) tick();
        fast_req = 1'b1;
        tick();
        fast_req = 1'b0;
        for (int k = 0; k < 30; k++) tick();
        chk(n_done == 1, "R13 single entry", n_done, 1);
        chk(n_ack == 0 && n_bk == 0, "R13 fast ignored while busy", n_ack, 0);
        chk(seen_addr == 32'h0000_1008 && got_pc == ~32'h0000_1008, "R10 slow fetch", got_pc, ~32'h0000_1008);
        mem_delay = 2;

        // R11 sleep set and woken by a masked request
        clr_obs();
        psw_in = mk_psw(1'b0, 4'd0);
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        tick();
        chk(asleep == 1'b1, "R11 sleep set", {31'b0, asleep}, 1);
        hw_req = 1'b1; hw_lvl = 4'd3; sleep_req = 1'b1;
        tick();
        hw_req = 1'b0; sleep_req = 1'b0;
        repeat (5) tick();
        chk(asleep == 1'b0, "R11 wake beats sleep", {31'b0, asleep}, 0);
        chk(n_done == 0, "R11 masked wake takes no entry", n_done, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule